// File: doc/BRIEF.md
# Iterative Lightweight Block Encryptor (64-bit block, 80-bit key)

This block encrypts one 64-bit block under an 80-bit key with an AES-like lightweight substitution-permutation cipher, one round per clock. The state is a 4x4 array of nibbles. Each round injects round constants, substitutes every nibble through a 4-bit S-box, rotates the rows and mixes the columns with an MDS matrix over GF(2^4). A 64-bit round key is not added every round. It is added once before the first round, once after every group of STEP rounds, and once more after the last round. Each round key is the upper 64 bits of an 80-bit key register. That register rotates left by 64 bit positions each time a key is added.

The block is used as a stream stage with three valid/ready channels. A key is taken first, then a plaintext block. After a fixed number of cycles the ciphertext is offered. Each channel completes a transfer on a rising clock edge where both valid and ready are high. The key and plaintext channels take one item per block, in that order. Their ready outputs never depend on their valid inputs. The ciphertext channel applies back-pressure: the result stays presented and unchanged until the consumer raises `ct_ready`. Only after that transfer does the block accept another key. Encryption only; each block needs a fresh key transfer.

Top module: `lwc80_enc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `key_ready` is 1 and `pt_ready` and `ct_valid` are 0. Reset is asynchronous and active low, and it also aborts a block in progress.
- R2: A key transfer (`key_valid` and `key_ready` high at a rising edge) stores `key` and moves the block to waiting for plaintext. From the next cycle `key_ready` is 0 and `pt_ready` is 1.
- R3: A plaintext transfer starts encryption. `ct_valid` first reads 1 exactly ROUNDS clock cycles after the transfer edge.
- R4: State layout: nibble (row r, column c) occupies bits [63-4(4r+c) -: 4] of `pt` and `ct`. Each round applies, in order: constant addition, S-box, row rotation and column mixing.
- R5: A round key is added before round 0, before every round whose index is a non-zero multiple of STEP (4), and after the final round: 13 additions for 48 rounds. Round key i is the 64 bits starting at the MSB of the 80-bit key after it has been rotated left by 64·i bits.
- R6: The round constant is a 6-bit LFSR s. It is cleared at block start and, before each round, updated to {s[4:0], s[5] XNOR s[4]}. Column 1 receives s[5:3] in rows 0 and 2 and s[2:0] in rows 1 and 3, each zero-extended to 4 bits. Column 0 receives r XOR 5 in rows 0 and 1 and r XOR 0 in rows 2 and 3.
- R7: The S-box maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Row r rotates left by r nibbles. Each column (rows 0..3, top first) is multiplied by the matrix with rows [4 1 2 2], [8 6 5 6], [B E A 9], [2 2 F B] over GF(2^4) modulo x^4+x+1.
- R8: While `ct_valid` is 1 and `ct_ready` is 0, `ct_valid` stays 1 and `ct` is unchanged. A ciphertext transfer returns the block to accepting a key (`key_ready` 1 on the next cycle).
- R9: `pt_valid` has no effect unless `pt_ready` is 1. `key_valid` has no effect unless `key_ready` is 1, including while a block is being encrypted.
- R10: At most one of `key_ready`, `pt_ready` and `ct_valid` is 1 at any time. All three are 0 during encryption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Key channel valid |
| key_ready | output | 1 | Key channel ready (idle) |
| key | input | 80 | Cipher key, bit 79 first |
| pt_valid | input | 1 | Plaintext channel valid |
| pt_ready | output | 1 | Plaintext channel ready |
| pt | input | 64 | Plaintext block |
| ct_valid | output | 1 | Ciphertext channel valid |
| ct_ready | input | 1 | Ciphertext channel ready from consumer |
| ct | output | 64 | Ciphertext block |

## Verification
The bench builds the block with its default parameters: 48 rounds, a key addition every 4 rounds and an 80-bit key. This covers the full 13-key schedule, in which the key register wraps through 768 bits of rotation. It also covers LFSR sequences long enough to revisit values. The reference model is an array-based description of the cipher, using the explicit mixing matrix rather than repeated companion steps. It is driven by the same parameters, so the latency window and the key-addition spacing it predicts follow ROUNDS and STEP. Stimulus includes stray valids on idle channels, a key offered during encryption, held back-pressure and a reset part-way through a block.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAITP = 2'd1,
    ST_ENC   = 2'd2,
    ST_OUT   = 2'd3
  } ctl_state_e;

  function automatic logic [3:0] sbox(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;
      4'h1: y = 4'h5;
      4'h2: y = 4'h6;
      4'h3: y = 4'hB;
      4'h4: y = 4'h9;
      4'h5: y = 4'h0;
      4'h6: y = 4'hA;
      4'h7: y = 4'hD;
      4'h8: y = 4'h3;
      4'h9: y = 4'hE;
      4'hA: y = 4'hF;
      4'hB: y = 4'h8;
      4'hC: y = 4'h4;
      4'hD: y = 4'h7;
      4'hE: y = 4'h1;
      default: y = 4'h2;
    endcase
    return y;
  endfunction

  // multiply by x modulo x^4 + x + 1
  function automatic logic [3:0] gf_x2(input logic [3:0] a);
    return {a[2:0], 1'b0} ^ (a[3] ? 4'h3 : 4'h0);
  endfunction

  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p;
    logic [3:0] sh;
    p  = 4'h0;
    sh = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ sh;
      sh = gf_x2(sh);
    end
    return p;
  endfunction

  // column mix as four companion-matrix steps (last row 4,1,2,2)
  function automatic logic [15:0] mix_col(input logic [15:0] v);
    logic [3:0] x0, x1, x2, x3, t;
    {x0, x1, x2, x3} = v;
    for (int k = 0; k < 4; k++) begin
      t  = gf_mul(x0, 4'h4) ^ x1 ^ gf_mul(x2, 4'h2) ^ gf_mul(x3, 4'h2);
      x0 = x1;
      x1 = x2;
      x2 = x3;
      x3 = t;
    end
    return {x0, x1, x2, x3};
  endfunction

endpackage

// File: rtl/lwc_round.sv
module lwc_round
  import lwc_pkg::*;
#(
  parameter int KEY_W = 80
) (
  input  logic [63:0] st_i,
  input  logic [5:0]  rc_i,
  output logic [63:0] st_o
);
  localparam logic [7:0] KSZ = 8'(KEY_W);

  logic [3:0] ac_n [16];
  logic [3:0] sb_n [16];
  logic [3:0] sr_n [16];
  logic [3:0] mc_n [16];

  for (genvar r = 0; r < 4; r++) begin : g_row
    for (genvar c = 0; c < 4; c++) begin : g_col
      localparam int IDX = 4 * r + c;
      localparam int SRC = 4 * r + ((c + r) % 4);
      logic [3:0] cst;
      if (c == 0) begin : g_c0
        assign cst = 4'(r) ^ ((r < 2) ? KSZ[7:4] : KSZ[3:0]);
      end else if (c == 1) begin : g_c1
        assign cst = (r % 2 == 0) ? {1'b0, rc_i[5:3]} : {1'b0, rc_i[2:0]};
      end else begin : g_cz
        assign cst = 4'h0;
      end
      assign ac_n[IDX] = st_i[63-4*IDX -: 4] ^ cst;
      assign sb_n[IDX] = sbox(ac_n[IDX]);
      assign sr_n[IDX] = sb_n[SRC];
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_mix
    assign {mc_n[c], mc_n[4+c], mc_n[8+c], mc_n[12+c]} =
      mix_col({sr_n[c], sr_n[4+c], sr_n[8+c], sr_n[12+c]});
  end

  for (genvar i = 0; i < 16; i++) begin : g_pack
    assign st_o[63-4*i -: 4] = mc_n[i];
  end
endmodule

// File: rtl/lwc_keyreg.sv
module lwc_keyreg #(
  parameter int KEY_W = 80,
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key_i,
  input  logic             rot,
  output logic [BLK_W-1:0] rk_o
);
  localparam int REST = KEY_W - BLK_W;

  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (load) key_q <= key_i;
    else if (rot) key_q <= {key_q[REST-1:0], key_q[KEY_W-1 -: BLK_W]};
  end

  assign rk_o = key_q[KEY_W-1 -: BLK_W];
endmodule

// File: rtl/lwc_round_ctr.sv
module lwc_round_ctr #(
  parameter int ROUNDS = 48,
  parameter int CW     = $clog2(ROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic [5:0]    rc_o
);
  logic [CW-1:0] cnt_q;
  logic [5:0]    rc_q;

  assign rc_o   = {rc_q[4:0], ~(rc_q[5] ^ rc_q[4])};
  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == CW'(ROUNDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rc_q  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      rc_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
      rc_q  <= rc_o;
    end
  end
endmodule

// File: rtl/lwc_ctrl.sv
module lwc_ctrl
  import lwc_pkg::*;
#(
  parameter int STEP = 4,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid,
  input  logic          pt_valid,
  input  logic          ct_ready,
  input  logic [CW-1:0] cnt,
  input  logic          done,
  output logic          key_ready,
  output logic          pt_ready,
  output logic          ct_valid,
  output logic          key_load,
  output logic          pt_load,
  output logic          round_en,
  output logic          sel_key,
  output logic          last
);
  ctl_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  assign key_ready = (st_q == ST_IDLE);
  assign pt_ready  = (st_q == ST_WAITP);
  assign ct_valid  = (st_q == ST_OUT);
  assign key_load  = key_ready & key_valid;
  assign pt_load   = pt_ready & pt_valid;
  assign round_en  = (st_q == ST_ENC);
  assign sel_key   = round_en && (cnt != '0) && ((int'(cnt) % STEP) == 0);
  assign last      = round_en & done;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (key_valid) st_d = ST_WAITP;
      ST_WAITP: if (pt_valid) st_d = ST_ENC;
      ST_ENC:   if (done) st_d = ST_OUT;
      ST_OUT:   if (ct_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lwc80_enc.sv
module lwc80_enc #(
  parameter int ROUNDS = 48,
  parameter int STEP   = 4,
  parameter int KEY_W  = 80,
  parameter int BLK_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key,
  input  logic             pt_valid,
  output logic             pt_ready,
  input  logic [BLK_W-1:0] pt,
  output logic             ct_valid,
  input  logic             ct_ready,
  output logic [BLK_W-1:0] ct
);
  localparam int CW = $clog2(ROUNDS);

  logic          key_load, pt_load, round_en, sel_key, last, done;
  logic [CW-1:0] cnt;
  logic [5:0]    rc;
  logic [BLK_W-1:0] rk, st_q, rin, rout;

  lwc_ctrl #(.STEP(STEP), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .key_valid(key_valid), .pt_valid(pt_valid), .ct_ready(ct_ready),
    .cnt(cnt), .done(done),
    .key_ready(key_ready), .pt_ready(pt_ready), .ct_valid(ct_valid),
    .key_load(key_load), .pt_load(pt_load), .round_en(round_en),
    .sel_key(sel_key), .last(last)
  );

  lwc_round_ctr #(.ROUNDS(ROUNDS), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(pt_load), .en(round_en),
    .cnt_o(cnt), .done_o(done), .rc_o(rc)
  );

  lwc_keyreg #(.KEY_W(KEY_W), .BLK_W(BLK_W)) u_key (
    .clk(clk), .rst_n(rst_n), .load(key_load), .key_i(key),
    .rot(pt_load | sel_key), .rk_o(rk)
  );

  assign rin = sel_key ? (st_q ^ rk) : st_q;

  lwc_round #(.KEY_W(KEY_W)) u_round (
    .st_i(rin), .rc_i(rc), .st_o(rout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else if (pt_load) st_q <= pt ^ rk;
    else if (round_en) st_q <= last ? (rout ^ rk) : rout;
  end

  assign ct = st_q;
endmodule

// File: rtl/lwc80_enc_chk.sv
module lwc80_enc_chk #(
  parameter int ROUNDS = 48,
  parameter int BLK_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_valid,
  input logic             key_ready,
  input logic             pt_valid,
  input logic             pt_ready,
  input logic             ct_valid,
  input logic             ct_ready,
  input logic [BLK_W-1:0] ct
);
  int lat_q;
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= 0;
      busy_q <= 1'b0;
    end else if (pt_valid && pt_ready) begin
      lat_q  <= 0;
      busy_q <= 1'b1;
    end else if (busy_q && !ct_valid) begin
      lat_q <= lat_q + 1;
    end else if (ct_valid) begin
      busy_q <= 1'b0;
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_ready, pt_ready, ct_valid}));

  p_key_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ready |=> pt_ready && !key_ready);

  p_start_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && pt_ready |=> !pt_ready && !key_ready && !ct_valid);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ct_valid) |-> busy_q && (lat_q == ROUNDS));

  p_ct_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid && !ct_ready |=> ct_valid && $stable(ct));

  p_ct_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid && ct_ready |=> key_ready && !ct_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready && !key_valid |=> key_ready);
endmodule

bind lwc80_enc lwc80_enc_chk #(.ROUNDS(ROUNDS), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
  .pt_valid(pt_valid), .pt_ready(pt_ready), .ct_valid(ct_valid),
  .ct_ready(ct_ready), .ct(ct)
);

// File: tb/lwc80_enc_bench.sv
`timescale 1ns/1ps
module lwc80_enc_bench;
  localparam int ROUNDS = 48;
  localparam int STEP   = 4;
  localparam int NKEYS  = ROUNDS / STEP + 1;
  localparam logic [63:0] SBOX_T = 64'hC56B_90AD_3EF8_4712;
  localparam logic [63:0] MIX_T  = 64'h4122_8656_BEA9_22FB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0, pt_valid = 1'b0, ct_ready = 1'b0;
  logic [79:0] key = '0;
  logic [63:0] pt = '0;
  logic key_ready, pt_ready, ct_valid;
  logic [63:0] ct;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lwc80_enc #(.ROUNDS(ROUNDS), .STEP(STEP)) u_lwc80_enc (
    .clk(clk), .rst_n(rst_n),
    .key_valid(key_valid), .key_ready(key_ready), .key(key),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt(pt),
    .ct_valid(ct_valid), .ct_ready(ct_ready), .ct(ct)
  );

  function automatic logic [3:0] ref_mul(logic [3:0] a, logic [3:0] b);
    logic [7:0] p = 8'h0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
    for (int i = 7; i >= 4; i--) if (p[i]) p = p ^ (8'h13 << (i - 4));
    return p[3:0];
  endfunction

  function automatic logic [63:0] ref_rk(logic [79:0] k, int idx);
    logic [63:0] r;
    for (int p = 0; p < 64; p++) r[63-p] = k[79 - ((p + 64 * idx) % 80)];
    return r;
  endfunction

  function automatic logic [63:0] ref_enc(logic [63:0] p, logic [79:0] k);
    logic [3:0] a [4][4];
    logic [3:0] b [4][4];
    logic [5:0] s = 6'h0;
    logic [63:0] rk;
    logic [63:0] res;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) a[r][c] = p[63-4*(4*r+c) -: 4];
    for (int kidx = 0; kidx < NKEYS; kidx++) begin
      rk = ref_rk(k, kidx);
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) a[r][c] = a[r][c] ^ rk[63-4*(4*r+c) -: 4];
      if (kidx == NKEYS - 1) break;
      for (int j = 0; j < STEP; j++) begin
        s = {s[4:0], ~(s[5] ^ s[4])};
        for (int r = 0; r < 4; r++) begin
          a[r][0] = a[r][0] ^ 4'(r) ^ ((r < 2) ? 4'h5 : 4'h0);
          a[r][1] = a[r][1] ^ ((r % 2 == 0) ? {1'b0, s[5:3]} : {1'b0, s[2:0]});
        end
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++) b[r][c] = SBOX_T[63-4*a[r][c] -: 4];
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++) a[r][c] = b[r][(c + r) % 4];
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++) begin
            b[r][c] = 4'h0;
            for (int m = 0; m < 4; m++)
              b[r][c] = b[r][c] ^ ref_mul(MIX_T[63-4*(4*r+m) -: 4], a[m][c]);
          end
        a = b;
      end
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) res[63-4*(4*r+c) -: 4] = a[r][c];
    return res;
  endfunction

  // cycle model: 0 idle, 1 waiting plaintext, 2 encrypting, 3 result offered
  int m_ph = 0;
  int m_cnt = 0;
  logic [79:0] m_key = '0;
  logic [63:0] m_ct = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph  <= 0;
      m_cnt <= 0;
    end else begin
      case (m_ph)
        0: if (key_valid) begin m_key <= key; m_ph <= 1; end
        1: if (pt_valid) begin m_ct <= ref_enc(pt, m_key); m_cnt <= 0; m_ph <= 2; end
        2: begin
          m_cnt <= m_cnt + 1;
          if (m_cnt + 1 == ROUNDS) m_ph <= 3;
        end
        default: if (ct_ready) m_ph <= 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(key_ready == (m_ph == 0), "R2 key_ready", 80'(key_ready), 80'(m_ph == 0));
      chk(pt_ready == (m_ph == 1), "R3 pt_ready", 80'(pt_ready), 80'(m_ph == 1));
      chk(ct_valid == (m_ph == 3), "R3 ct_valid timing", 80'(ct_valid), 80'(m_ph == 3));
      if (m_ph == 3 && ct_valid)
        chk(ct == m_ct, "R4 R5 R6 R7 R8 ciphertext", 80'(ct), 80'(m_ct));
      if (m_ph == 2)
        chk(!key_ready && !pt_ready && !ct_valid, "R10 quiet while busy",
            80'({key_ready, pt_ready, ct_valid}), 80'(0));
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      summary_and_end();
    end
  end

  task automatic run_block(input logic [79:0] k, input logic [63:0] p,
                           input int hold, input bit late_key);
    @(negedge clk);
    key = k;
    key_valid = 1'b1;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    pt = p;
    pt_valid = 1'b1;
    while (!pt_ready) @(negedge clk);
    @(negedge clk);
    pt_valid = 1'b0;
    if (late_key) begin
      key = ~k;          // R9: offered while encrypting, must be ignored
      key_valid = 1'b1;
    end
    while (!ct_valid) @(negedge clk);
    key_valid = 1'b0;
    for (int i = 0; i < hold; i++) @(negedge clk);   // R8 back-pressure
    ct_ready = 1'b1;
    @(negedge clk);
    ct_ready = 1'b0;
    chk(key_ready && !ct_valid, "R8 release to idle", 80'({key_ready, ct_valid}), 80'(2'b10));
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(key_ready && !pt_ready && !ct_valid, "R1 reset state",
        80'({key_ready, pt_ready, ct_valid}), 80'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(key_ready && !pt_ready && !ct_valid, "R1 after release",
        80'({key_ready, pt_ready, ct_valid}), 80'(3'b100));

    run_block(80'h0, 64'h0, 0, 1'b0);
    run_block({80{1'b1}}, {64{1'b1}}, 2, 1'b0);
    run_block(80'h0123_4567_89AB_CDEF_0123, 64'h0123_4567_89AB_CDEF, 0, 1'b0);
    run_block(80'h8000_0000_0000_0000_0001, 64'h0000_0000_0000_0001, 5, 1'b0);

    // R9: plaintext strobes while idle have no effect
    @(negedge clk);
    pt = 64'hDEAD_BEEF_0000_FFFF;
    pt_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(key_ready && !pt_ready && !ct_valid, "R9 pt_valid ignored in idle",
        80'({key_ready, pt_ready, ct_valid}), 80'(3'b100));
    pt_valid = 1'b0;

    run_block(80'hF0E1_D2C3_B4A5_9687_7869, 64'h1122_3344_5566_7788, 3, 1'b1);
    run_block(80'h5A5A_A5A5_3C3C_C3C3_0F0F, 64'hFEDC_BA98_7654_3210, 0, 1'b0);

    // R1: reset part-way through a block
    @(negedge clk);
    key = 80'h1357_9BDF_0246_8ACE_1234;
    key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    pt = 64'hA5A5_5A5A_C3C3_3C3C;
    pt_valid = 1'b1;
    @(negedge clk);
    pt_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(key_ready && !pt_ready && !ct_valid, "R1 reset aborts block",
        80'({key_ready, pt_ready, ct_valid}), 80'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);

    run_block(80'hCAFE_F00D_1234_5678_9ABC, 64'h0F1E_2D3C_4B5A_6978, 1, 1'b0);
    repeat (3) @(negedge clk);
    summary_and_end();
  end
endmodule